// File: doc/BRIEF.md
# Reference Divider with Fractional Front End and Auxiliary Clock Tap

This block divides a single reference clock down to the comparison pulse of a phase detector. The programmed ratio is counted in two stages. A front-end prescaler divides by 2 or by 2.5. A back-end counter then counts prescaler outputs up to a terminal count. The prescaler output also feeds a small auxiliary counter. That counter produces a reference-derived clock at the input rate divided by 8, 10 or 12.5.

Divide by 2.5 is made by alternating prescaler periods of 2 and 3 input cycles. When the auxiliary clock is off, the prescaler is bypassed and the back-end counter counts input cycles directly. Because of this, only certain ratios are legal while the auxiliary clock runs. A load strobe captures a new ratio, and the new ratio is applied at the next terminal count. A ratio that is illegal in the current mode raises an error flag and is discarded.

Top module: `refdiv_tap`

## Requirements
- R1: While `rst_n` is low, `pulse_o`, `aux_o` and `ratio_err` are 0 and the active ratio is `RST_RATIO` (default 20). The first `pulse_o` appears after the 20th rising clock edge following reset release.
- R2: `pulse_o` is high for exactly one input clock once per division cycle. The division cycle is the active ratio counted in input clocks.
- R3: With `mode_hi` = 1, `aux_o` stays 0 and the prescaler is bypassed, whatever `aux_sel` holds. Any ratio of 2 or more is legal.
- R4: With `mode_hi` = 0, `aux_sel` selects the auxiliary divide: 2'b00 gives /8 (prescaler /2, auxiliary counter /4), 2'b01 gives /10 (/2, /5) and 2'b10 gives /12.5 (/2.5, /5). In the /12.5 case the periods alternate 12 and 13 input cycles. Counting prescaler outputs from reset, `aux_o` goes high on the output that completes an auxiliary count and goes low on the second output after that.
- R5: With `mode_hi` = 0 and `aux_sel` = 2'b11, the auxiliary clock is off. `aux_o` stays 0 and the prescaler is bypassed, as in R3.
- R6: While the auxiliary clock runs, a ratio is legal only if it is at least 2 and even (for /8 and /10), or at least 5 and a multiple of 5 (for /12.5). In every mode, a ratio below 2 is illegal.
- R7: `ratio_err` changes only on a clock edge that samples `load` high. It becomes 1 when the sampled ratio is illegal and 0 when it is legal. An illegal ratio leaves the active ratio unchanged.
- R8: A legal loaded ratio becomes active at the next terminal count, so the running division cycle completes at its old length. When several loads occur before that terminal count, the last legal one wins. A load sampled on the terminal edge itself applies immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio | input | W (16) | Overall divide ratio to load |
| aux_sel | input | 2 | Auxiliary divide select (00 /8, 01 /10, 10 /12.5, 11 off) |
| mode_hi | input | 1 | High forbids the auxiliary clock and lifts the ratio restriction |
| load | input | 1 | One-cycle strobe that captures `ratio` |
| pulse_o | output | 1 | One-clock comparison pulse per division cycle |
| aux_o | output | 1 | Auxiliary reference-derived clock |
| ratio_err | output | 1 | Last loaded ratio was illegal |

## Verification
The assertions assume that `mode_hi` and `aux_sel` change only while `rst_n` is low, since the prescaler phase and the terminal count are derived from them. They also assume that `load` is a synchronous strobe. The stimulus changes mode and selector only inside a reset pulse, and drives every input on the falling edge. Each mode is then run with legal, illegal, back-to-back and minimum ratios. The behavioural model predicts the waveforms from cycle and prescaler-output counts since reset.

// File: rtl/refdiv_tap.sv
module refdiv_tap #(
  parameter int W = 16,
  parameter int RST_RATIO = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ratio,
  input  logic [1:0]   aux_sel,
  input  logic         mode_hi,
  input  logic         load,
  output logic         pulse_o,
  output logic         aux_o,
  output logic         ratio_err
);
  localparam logic [1:0] SEL_8   = 2'b00;
  localparam logic [1:0] SEL_125 = 2'b10;
  localparam logic [1:0] SEL_OFF = 2'b11;
  localparam logic [W:0] FIVE    = (W+1)'(5);

  logic aux_on, f25, pre_tick, term, ld_ok, has_pend, half, aux_q, pulse_q, err_q;
  logic [W-1:0] act_r, pend_r, bk_cnt, tc;
  logic [1:0] pre_cnt, pre_lim;
  logic [2:0] aux_cnt, aux_lim;

  assign aux_on  = !mode_hi && (aux_sel != SEL_OFF);
  assign f25     = aux_on && (aux_sel == SEL_125);
  assign aux_lim = (aux_sel == SEL_8) ? 3'd4 : 3'd5;
  assign pre_lim = (f25 && half) ? 2'd3 : 2'd2;

  function automatic logic legal(input logic [W-1:0] r, input logic on, input logic q);
    if (r < W'(2))  return 1'b0;
    if (!on)        return 1'b1;
    if (q)          return ({1'b0, r} % FIVE) == '0;
    return !r[0];
  endfunction

  function automatic logic [W-1:0] tc_of(input logic [W-1:0] r, input logic on, input logic q);
    logic [W:0] dbl;
    dbl = {r, 1'b0};
    if (!on) return r;
    if (q)   return W'(dbl / FIVE);
    return r >> 1;
  endfunction

  assign tc       = tc_of(act_r, aux_on, f25);
  assign pre_tick = !aux_on || (pre_cnt == pre_lim - 2'd1);
  assign term     = pre_tick && (bk_cnt == tc - W'(1));
  assign ld_ok    = load && legal(ratio, aux_on, f25);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      half    <= 1'b0;
    end else if (pre_tick) begin
      pre_cnt <= '0;
      half    <= f25 && !half;
    end else begin
      pre_cnt <= pre_cnt + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bk_cnt   <= '0;
      pulse_q  <= 1'b0;
      act_r    <= W'(RST_RATIO);
      pend_r   <= '0;
      has_pend <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      pulse_q <= term;
      if (term) bk_cnt <= '0;
      else if (pre_tick) bk_cnt <= bk_cnt + W'(1);
      if (term) begin
        if (ld_ok) begin
          act_r    <= ratio;
          has_pend <= 1'b0;
        end else if (has_pend) begin
          act_r    <= pend_r;
          has_pend <= 1'b0;
        end
      end else if (ld_ok) begin
        pend_r   <= ratio;
        has_pend <= 1'b1;
      end
      if (load) err_q <= !legal(ratio, aux_on, f25);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aux_cnt <= '0;
      aux_q   <= 1'b0;
    end else if (!aux_on) begin
      aux_cnt <= '0;
      aux_q   <= 1'b0;
    end else if (pre_tick) begin
      if (aux_cnt == aux_lim - 3'd1) begin
        aux_cnt <= '0;
        aux_q   <= 1'b1;
      end else begin
        aux_cnt <= aux_cnt + 3'd1;
        if (aux_cnt == 3'd1) aux_q <= 1'b0;
      end
    end
  end

  assign pulse_o   = pulse_q;
  assign aux_o     = aux_q;
  assign ratio_err = err_q;
endmodule

// File: rtl/refdiv_tap_chk.sv
module refdiv_tap_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] ratio,
  input logic [1:0]   aux_sel,
  input logic         mode_hi,
  input logic         load,
  input logic         pulse_o,
  input logic         aux_o,
  input logic         ratio_err
);
  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

  assert_aux_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_hi |-> !aux_o);

  assert_aux_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_hi && aux_sel == 2'b11) |-> !aux_o);

  assert_odd_rejected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !mode_hi && (aux_sel == 2'b00 || aux_sel == 2'b01) && ratio[0]) |=> ratio_err);

  assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(ratio_err));

  assert_low_rejected_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ratio < W'(2)) |=> ratio_err);
endmodule

bind refdiv_tap refdiv_tap_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ratio(ratio), .aux_sel(aux_sel), .mode_hi(mode_hi),
  .load(load), .pulse_o(pulse_o), .aux_o(aux_o), .ratio_err(ratio_err)
);

// File: tb/refdiv_tap_tb.sv
module refdiv_tap_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ratio = '0;
  logic [1:0]  aux_sel = '0;
  logic        mode_hi = 1'b1;
  logic        load = 1'b0;
  logic        pulse_o, aux_o, ratio_err;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_cnt, m_act, m_pend, m_edge, m_tick;
  bit m_has_pend, e_pulse, e_aux, e_err;

  refdiv_tap u_dut (.clk(clk), .rst_n(rst_n), .ratio(ratio), .aux_sel(aux_sel),
    .mode_hi(mode_hi), .load(load), .pulse_o(pulse_o), .aux_o(aux_o), .ratio_err(ratio_err));

  always #2 clk = ~clk;

  function automatic bit legal(int r, bit mh, logic [1:0] s);
    if (r < 2) return 0;
    if (mh || s == 2'b11) return 1;
    if (s == 2'b10) return (r % 5) == 0;
    return (r % 2) == 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_cnt = 0; m_act = 20; m_pend = 0; m_has_pend = 0;
      m_edge = 0; m_tick = 0; e_pulse = 0; e_aux = 0; e_err = 0;
    end else begin
      bit ok, on, tick;
      int a;
      ok = legal(ratio, mode_hi, aux_sel);
      on = !mode_hi && aux_sel != 2'b11;
      m_cnt++;
      e_pulse = (m_cnt == m_act);
      if (e_pulse) begin
        m_cnt = 0;
        if (load && ok) begin m_act = ratio; m_has_pend = 0; end
        else if (m_has_pend) begin m_act = m_pend; m_has_pend = 0; end
      end else if (load && ok) begin
        m_pend = ratio; m_has_pend = 1;
      end
      if (load) e_err = !ok;
      if (on) begin
        tick = (aux_sel == 2'b10) ? (m_edge % 5 == 1 || m_edge % 5 == 4) : (m_edge % 2 == 1);
        a = (aux_sel == 2'b00) ? 4 : 5;
        if (tick) begin
          if (m_tick % a == a - 1) e_aux = 1;
          else if (m_tick % a == 1) e_aux = 0;
          m_tick++;
        end
      end else e_aux = 0;
      m_edge++;
    end
  end

  always @(negedge clk) begin
    chk("R2 R8 pulse", pulse_o, e_pulse);
    chk("R4 aux", aux_o, e_aux);
    chk("R7 err", ratio_err, e_err);
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(bit mh, logic [1:0] s);
    @(negedge clk);
    rst_n = 0; mode_hi = mh; aux_sel = s;
    run(3);
    rst_n = 1;
  endtask

  task automatic do_load(int r);
    ratio = 16'(r); load = 1;
    @(negedge clk);
    load = 0;
  endtask

  initial begin
    fork
      begin
        rst_n = 0;
        run(3);
        chk("R1 pulse in reset", pulse_o, 0);
        chk("R1 aux in reset", aux_o, 0);
        chk("R1 err in reset", ratio_err, 0);
        rst_n = 1;
        run(19); chk("R1 no early pulse", pulse_o, 0);
        run(1);  chk("R1 first pulse", pulse_o, 1);
        run(30);
        do_load(7);  chk("R3 odd ratio legal", ratio_err, 0);
        run(40);
        do_load(1);  chk("R7 ratio 1 rejected", ratio_err, 1);
        run(20);
        do_load(3); do_load(9);
        run(50);
        do_load(2);  chk("R3 minimum ratio", ratio_err, 0);
        run(20);
        do_reset(1, 2'b10);
        run(10);
        do_load(7);  chk("R3 select ignored", ratio_err, 0);
        chk("R3 aux low", aux_o, 0);
        run(40);
        do_reset(0, 2'b00);
        run(50);
        do_load(12);
        do_load(7);  chk("R6 odd rejected /8", ratio_err, 1);
        run(60);
        do_load(2);
        run(40);
        do_reset(0, 2'b01);
        run(50);
        do_load(10);
        do_load(0);  chk("R6 zero rejected /10", ratio_err, 1);
        run(60);
        do_reset(0, 2'b10);
        run(60);
        do_load(25);
        do_load(12); chk("R6 non multiple of 5 rejected", ratio_err, 1);
        run(80);
        do_load(15); chk("R6 multiple of 5 accepted", ratio_err, 0);
        run(80);
        do_load(5);
        run(60);
        do_reset(0, 2'b11);
        run(30);
        do_load(3);  chk("R5 odd ratio legal with aux off", ratio_err, 0);
        chk("R5 aux low", aux_o, 0);
        run(30);
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule